// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds two IEEE-754 binary32 operands. The word layout is the sign in bit 31, the biased exponent in bits 30:23 and the stored fraction in bits 22:0. The block takes one operand pair per clock when `in_valid` is high, so its throughput is one addition per cycle. The work is split over four register stages. The first stage finds the larger-magnitude operand and swaps the pair if needed. The second stage inserts the hidden bit, aligns the smaller mantissa, and takes its two's complement when the signs differ. The third stage adds the mantissas. The fourth stage normalises, rounds and packs the result.

Rounding is always round-to-nearest, ties-to-even. Subnormal operands are read as zero of the same sign, and results that would be subnormal come out as zero. Infinities and NaNs bypass the datapath in a flag that moves alongside each operation. Every NaN output is the single quiet pattern 0x7FC00000.

Top module: `fp32_pipe_adder`

## Requirements
- R1: Operands sampled with `in_valid` high on a rising edge give `out_valid` high with their sum after the fourth rising edge, counting the capturing edge. A new pair may enter on every cycle.
- R2: For finite normal operands, `out_sum` is the exact sum rounded to nearest, with ties going to the even fraction.
- R3: The result takes the sign of the operand with the larger magnitude. Magnitude is ordered by exponent first, then by fraction. When the signs differ, the magnitudes are subtracted.
- R4: Alignment keeps guard, round and sticky bits. An exponent gap of 26 or more reduces the smaller operand to a sticky bit only. For example, 1.0 plus or minus 2^-30 gives 1.0, and 0x3F800001 plus 2^-24 rounds up to 0x3F800002.
- R5: If either input is a NaN (exponent 255, fraction nonzero), or the inputs are infinities of opposite sign, the output is 0x7FC00000.
- R6: An infinity (exponent 255, fraction zero) added to a finite value, or to an infinity of the same sign, gives that infinity.
- R7: An input with exponent 0 is treated as a zero of its own sign, whatever its fraction.
- R8: A zero result from adding operands of opposite sign is +0 (0x00000000). The sum of two zeros of the same sign keeps that sign.
- R9: A rounded exponent of 255 or more gives an infinity of the result's sign. A rounded exponent of 0 or less gives a zero of the result's sign, so no output is ever subnormal.
- R10: `out_valid` is low after reset. It is also low four edges after any cycle in which `in_valid` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears the valid pipeline |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 32 | First binary32 operand |
| in_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | `out_sum` holds a result |
| out_sum | output | 32 | Rounded binary32 sum |

## Verification
The block has no parameters, so the bench builds it in its fixed single-precision form. Random operands mostly have exponents within 28 of each other. This reaches the carry-out, deep cancellation and round-to-even paths, and it keeps the bench's double-precision reference free of double rounding. A fraction of the operands are random specials, subnormals, negated copies and widely separated exponents. Directed cases pin down the sticky-only gap, tie rounding, overflow at the top exponent, underflow to zero and the signs of zero results.

// File: rtl/fp32_pipe_adder.sv
module fp32_pipe_adder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_a,
  input  logic [31:0] in_b,
  output logic        out_valid,
  output logic [31:0] out_sum
);

  // stage 1: classify, order by magnitude
  logic [7:0]  ea, eb;
  logic        za, zb, nan_a, nan_b, inf_a, inf_b, a_big;
  logic [23:0] ma, mb;
  logic [31:0] spc_word;

  assign ea    = in_a[30:23];
  assign eb    = in_b[30:23];
  assign za    = (ea == 8'd0);
  assign zb    = (eb == 8'd0);
  assign ma    = za ? 24'd0 : {1'b1, in_a[22:0]};
  assign mb    = zb ? 24'd0 : {1'b1, in_b[22:0]};
  assign nan_a = (&ea) & (|in_a[22:0]);
  assign nan_b = (&eb) & (|in_b[22:0]);
  assign inf_a = (&ea) & ~(|in_a[22:0]);
  assign inf_b = (&eb) & ~(|in_b[22:0]);
  assign a_big = {ea, ma} >= {eb, mb};
  assign spc_word = (nan_a | nan_b | (inf_a & inf_b & (in_a[31] ^ in_b[31]))) ? 32'h7FC00000 :
                    inf_a ? {in_a[31], 8'hFF, 23'd0} : {in_b[31], 8'hFF, 23'd0};

  logic        s1_v, s1_sign, s1_sub, s1_spc;
  logic [7:0]  s1_exp, s1_d;
  logic [23:0] s1_mbig, s1_msml;
  logic [31:0] s1_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s1_v <= 1'b0;
    else        s1_v <= in_valid;

  always_ff @(posedge clk) begin
    s1_sign <= a_big ? in_a[31] : in_b[31];
    s1_exp  <= a_big ? ea : eb;
    s1_d    <= a_big ? ea - eb : eb - ea;
    s1_mbig <= a_big ? ma : mb;
    s1_msml <= a_big ? mb : ma;
    s1_sub  <= in_a[31] ^ in_b[31];
    s1_spc  <= nan_a | nan_b | inf_a | inf_b;
    s1_word <= spc_word;
  end

  // stage 2: align with guard/round/sticky, complement on subtract
  logic [26:0] ext, shf, al;
  logic        lost;
  logic [27:0] sml28;

  assign ext  = {s1_msml, 3'b000};
  assign shf  = ext >> s1_d;
  assign lost = |(ext & ~({27{1'b1}} << s1_d));
  assign al   = (s1_d >= 8'd27) ? {26'd0, |ext} : {shf[26:1], shf[0] | lost};
  assign sml28 = {1'b0, al};

  logic        s2_v, s2_sign, s2_sub, s2_spc;
  logic [7:0]  s2_exp;
  logic [27:0] s2_a, s2_b;
  logic [31:0] s2_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s2_v <= 1'b0;
    else        s2_v <= s1_v;

  always_ff @(posedge clk) begin
    s2_sign <= s1_sign;
    s2_sub  <= s1_sub;
    s2_spc  <= s1_spc;
    s2_exp  <= s1_exp;
    s2_word <= s1_word;
    s2_a    <= {1'b0, s1_mbig, 3'b000};
    s2_b    <= s1_sub ? (~sml28 + 28'd1) : sml28;
  end

  // stage 3: add
  logic        s3_v, s3_sign, s3_sub, s3_spc;
  logic [7:0]  s3_exp;
  logic [27:0] s3_sum;
  logic [31:0] s3_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s3_v <= 1'b0;
    else        s3_v <= s2_v;

  always_ff @(posedge clk) begin
    s3_sign <= s2_sign;
    s3_sub  <= s2_sub;
    s3_spc  <= s2_spc;
    s3_exp  <= s2_exp;
    s3_word <= s2_word;
    s3_sum  <= s2_a + s2_b;
  end

  // stage 4: normalise, round to nearest even, pack
  function automatic logic [4:0] lead_zeros(input logic [26:0] x);
    logic [4:0] n;
    n = 5'd27;
    for (int i = 0; i < 27; i++)
      if (x[i]) n = 5'(26 - i);
    return n;
  endfunction

  logic [4:0]         lz;
  logic [26:0]        nrm;
  logic signed [9:0]  e_n, e_f;
  logic               rnd;
  logic [24:0]        mr;
  logic [22:0]        frac;
  logic [31:0]        result;

  assign lz   = lead_zeros(s3_sum[26:0]);
  assign nrm  = s3_sum[27] ? {s3_sum[27:2], s3_sum[1] | s3_sum[0]} : (s3_sum[26:0] << lz);
  assign e_n  = s3_sum[27] ? $signed({2'b00, s3_exp}) + 10'sd1
                           : $signed({2'b00, s3_exp}) - $signed({5'd0, lz});
  assign rnd  = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
  assign mr   = {1'b0, nrm[26:3]} + {24'd0, rnd};
  assign e_f  = e_n + $signed({9'd0, mr[24]});
  assign frac = mr[24] ? mr[23:1] : mr[22:0];

  always_comb begin
    if (s3_spc)                 result = s3_word;
    else if (s3_sum == 28'd0)   result = {s3_sign & ~s3_sub, 31'd0};
    else if (e_f >= 10'sd255)   result = {s3_sign, 8'hFF, 23'd0};
    else if (e_f <= 10'sd0)     result = {s3_sign, 31'd0};
    else                        result = {s3_sign, e_f[7:0], frac};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s3_v;

  always_ff @(posedge clk) out_sum <= result;

  assert_valid_chain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s3_v |=> out_valid);

  assert_gap_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !s1_spc && s1_d >= 8'd26) |=>
      (s2_sub ? (s2_b == 28'd0 || (&s2_b)) : (s2_b <= 28'd1)));

  assert_nan_canon_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&out_sum[30:23])) |-> (out_sum[22:0] == 23'd0 || out_sum == 32'h7FC00000));

  assert_cancel_pos_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_v && !s3_spc && s3_sub && s3_sum == 28'd0) |=> (out_sum == 32'h00000000));

  assert_no_denorm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sum[30:23] != 8'd0 || out_sum[22:0] == 23'd0));

endmodule

// File: tb/tb_fp32_pipe_adder.sv
`timescale 1ns/1ps
module tb_fp32_pipe_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [31:0] out_sum;

  fp32_pipe_adder dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a),
                       .in_b(in_b), .out_valid(out_valid), .out_sum(out_sum));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, step_n = 0;
  bit done = 1'b0;
  logic        hv[8];
  logic [31:0] hexp[8];
  string       htag[8];

  function automatic real to_real(input logic [31:0] x);
    if (x[30:23] == 8'd0) return $bitstoreal({x[31], 63'd0});
    return $bitstoreal({x[31], {3'd0, x[30:23]} + 11'd896, x[22:0], 29'd0});
  endfunction

  function automatic logic [31:0] from_real(input real r);
    logic [63:0] b;
    int se;
    logic [24:0] m;
    logic up;
    b = $realtobits(r);
    if (b[62:0] == 63'd0) return {b[63], 31'd0};
    se = int'(b[62:52]) - 896;
    up = b[28] & ((|b[27:0]) | b[29]);
    m  = {2'b01, b[51:29]} + {24'd0, up};
    if (m[24]) se++;
    if (se >= 255) return {b[63], 8'hFF, 23'd0};
    if (se <= 0)   return {b[63], 31'd0};
    return {b[63], 8'(se), m[24] ? 23'd0 : m[22:0]};
  endfunction

  function automatic logic [31:0] ref_add(input logic [31:0] a, input logic [31:0] b);
    logic na, nb, ia, ib;
    na = (&a[30:23]) && (a[22:0] != 0);
    nb = (&b[30:23]) && (b[22:0] != 0);
    ia = (&a[30:23]) && (a[22:0] == 0);
    ib = (&b[30:23]) && (b[22:0] == 0);
    if (na || nb || (ia && ib && a[31] != b[31])) return 32'h7FC00000;
    if (ia) return a;
    if (ib) return b;
    return from_real(to_real(a) + to_real(b));
  endfunction

  function automatic string tag_of(input logic [31:0] a, input logic [31:0] b);
    if ((&a[30:23]) || (&b[30:23])) return ((a[22:0] != 0 && (&a[30:23])) ||
                                            (b[22:0] != 0 && (&b[30:23]))) ? "R5" : "R6";
    if (a[30:23] == 0 || b[30:23] == 0) return "R7";
    if (a[31] != b[31]) return "R3";
    return "R2";
  endfunction

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] exp_sum, input string tag);
    @(negedge clk);
    if (step_n >= 4) begin
      int k = (step_n - 4) % 8;
      checks++;
      if (out_valid !== hv[k]) begin
        fails++;
        $display("FAIL %s valid: got %b expected %b", hv[k] ? "R1" : "R10", out_valid, hv[k]);
      end
      if (hv[k]) begin
        checks++;
        if (out_sum !== hexp[k]) begin
          fails++;
          $display("FAIL %s sum: got %h expected %h", htag[k], out_sum, hexp[k]);
        end
      end
    end
    in_valid = v; in_a = a; in_b = b;
    hv[step_n % 8] = v; hexp[step_n % 8] = exp_sum; htag[step_n % 8] = tag;
    step_n++;
  endtask

  task automatic dir(input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] e, input string tag);
    step(1'b1, a, b, e, tag);
  endtask

  function automatic logic [31:0] rand_special();
    case ($urandom % 6)
      0: return 32'h7F800000;
      1: return 32'hFF800000;
      2: return {1'($urandom), 8'hFF, 23'($urandom) | 23'd1};
      3: return {1'($urandom), 8'h00, 23'($urandom)};
      4: return {1'($urandom), 31'd0};
      default: return {1'($urandom), 8'hFE, 23'($urandom)};
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: got %b expected 0", out_valid);
    end
    rst_n = 1'b1;

    // R2 plain add and rounding
    dir(32'h3F800000, 32'h40000000, 32'h40400000, "R2");
    // R3 sign of larger magnitude, subtraction
    dir(32'h40000000, 32'hBF800000, 32'h3F800000, "R3");
    dir(32'hBF800000, 32'h40000000, 32'h3F800000, "R3");
    dir(32'h3FC00000, 32'hBFE00000, 32'hBE800000, "R3");
    // R4 sticky-only gap and ties
    dir(32'h3F800000, 32'h30800000, 32'h3F800000, "R4");
    dir(32'h3F800000, 32'hB0800000, 32'h3F800000, "R4");
    dir(32'h3F800001, 32'h33800000, 32'h3F800002, "R4");
    dir(32'h3F800000, 32'h33800000, 32'h3F800000, "R4");
    step(1'b0, 32'h0, 32'h0, 32'h0, "R10");
    // R5 NaN outputs
    dir(32'h7FC00001, 32'h3F800000, 32'h7FC00000, "R5");
    dir(32'h7F800000, 32'hFF800000, 32'h7FC00000, "R5");
    dir(32'hFF800001, 32'h7F800000, 32'h7FC00000, "R5");
    // R6 infinity propagation
    dir(32'h7F800000, 32'h3F800000, 32'h7F800000, "R6");
    dir(32'hFF800000, 32'hFF800000, 32'hFF800000, "R6");
    dir(32'h3F800000, 32'hFF800000, 32'hFF800000, "R6");
    // R7 subnormal inputs as zero
    dir(32'h00000001, 32'h3F800000, 32'h3F800000, "R7");
    dir(32'h00400000, 32'h00400000, 32'h00000000, "R7");
    dir(32'h807FFFFF, 32'h807FFFFF, 32'h80000000, "R7");
    // R8 zero signs
    dir(32'h3F800000, 32'hBF800000, 32'h00000000, "R8");
    dir(32'h80000000, 32'h80000000, 32'h80000000, "R8");
    dir(32'h80000001, 32'h00000000, 32'h00000000, "R8");
    // R9 overflow and underflow
    dir(32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, "R9");
    dir(32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, "R9");
    dir(32'h00800001, 32'h80800000, 32'h00000000, "R9");
    dir(32'h80800001, 32'h00800000, 32'h80000000, "R9");
    step(1'b0, 32'h0, 32'h0, 32'h0, "R10");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      int ea_i, eb_i, d;
      logic v;
      ea_i = 1 + int'($urandom % 254);
      d = int'($urandom % 57) - 28;
      eb_i = (n % 10 == 0) ? 1 + int'($urandom % 254) : ea_i + d;
      if (eb_i < 1) eb_i = 1;
      if (eb_i > 254) eb_i = 254;
      a = {1'($urandom), 8'(ea_i), 23'($urandom)};
      b = {1'($urandom), 8'(eb_i), 23'($urandom)};
      if (n % 13 == 0) b = {~a[31], a[30:23], a[22:0] ^ 23'($urandom % 8)};
      if ($urandom % 16 == 0) a = rand_special();
      if ($urandom % 16 == 0) b = rand_special();
      v = ($urandom % 5) != 0;
      step(v, a, b, ref_add(a, b), v ? tag_of(a, b) : "R10");
    end
    repeat (6) step(1'b0, 32'h0, 32'h0, 32'h0, "R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule